// File: doc/BRIEF.md
# Adder-Subtracter with Unsigned and Signed Overflow Flags

This block is a purely combinational two's-complement adder-subtracter. It has one `mode` input. When `mode` is 0 the result is `x + y`. When `mode` is 1 the result is `x - y`, computed as `x + ~y + 1`. The same carry network serves both operations. A small conditioning stage inverts the second operand and raises the carry-in when subtracting.

Carries come from 4-bit lookahead groups. Inside a group, every carry is computed directly from the generate signals, the propagate signals and the group carry-in. Between groups the carry ripples. Two flags come from the carries at the top of the word:

- The unsigned flag is the carry-out when adding and the inverted carry-out when subtracting, so it signals a borrow.
- The signed flag is set when the carry into the sign bit differs from the carry out of it.

A surrounding datapath reads whichever flag matches its interpretation of the operands.

Top module: `adsub_dual_flag`

## Requirements
- R1: With mode = 0 (add), result equals (x + y) mod 2^WIDTH.
- R2: With mode = 1 (subtract), result equals (x - y) mod 2^WIDTH.
- R3: With mode = 0, unsigned_flag is 1 exactly when x + y, taken as unsigned integers, is at least 2^WIDTH.
- R4: With mode = 1, unsigned_flag is 1 exactly when x < y as unsigned integers (borrow).
- R5: With mode = 0, signed_flag is 1 exactly when the sum of x and y, read as two's-complement values (bit WIDTH-1 is the sign), lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: With mode = 1, signed_flag is 1 exactly when x - y, read as two's-complement values, lies outside that same range.
- R7: The two flags are independent: both, either or neither may be 1 for the same operands. For example, with WIDTH = 12, adding 0x800 + 0x800 gives result 0 with both flags set.
- R8: WIDTH is a parameter and must be a multiple of 4. The default is 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand (subtrahend in subtract mode) |
| mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| unsigned_flag | output | 1 | Carry-out when adding, borrow when subtracting |
| signed_flag | output | 1 | Two's-complement overflow |

## Verification
The unsigned and signed flags come from the same two top carries, so a single operand pair can raise both at once. A fault in one flag's decode can therefore hide behind the other. The bench provokes the coincidence with operand pairs such as 0x800 + 0x800 and 0x000 - 0x800, where both flags must rise together. It also uses pairs where exactly one flag rises, such as 0x7FF + 0x001 and 0xFFF + 0x001. Each flag is judged separately against integer reference arithmetic computed in the bench.

// File: rtl/adsub_pkg.sv
// Package: shared constants and types for the adder-subtracter.
// Assumes: operand widths are whole multiples of LANE_W.
package adsub_pkg;
    localparam int LANE_W = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/adsub_operand_prep.sv
// Module: conditions the second operand for the shared carry network.
// In subtract mode every bit of y is inverted and the carry-in is forced
// high, so the downstream adder computes x + ~y + 1.
// Assumes: mode is a plain 0/1 select with no X.
module adsub_operand_prep
    import adsub_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] y_in,
    input  logic             mode,
    output logic [WIDTH-1:0] y_cond,
    output logic             carry_seed
);
    op_e op;

    // Purpose: decode the operation and apply the complement trick.
    always_comb begin
        op         = op_e'(mode);
        y_cond     = (op == OP_SUB) ? ~y_in : y_in;
        carry_seed = (op == OP_SUB);
    end
endmodule

// File: rtl/adsub_cla4.sv
// Module: one 4-bit carry-lookahead lane.
// Each carry is computed directly from the lane's generate and propagate
// terms and its carry-in, with no ripple inside the lane.
// Assumes: prop = a ^ b and gen = a & b per bit.
module adsub_cla4 (
    input  logic [3:0] gen,
    input  logic [3:0] prop,
    input  logic       cin,
    output logic [3:0] sum,
    output logic [4:1] cout
);
    // Purpose: flat lookahead equations for c1..c4.
    always_comb begin
        cout[1] = gen[0] | (prop[0] & cin);
        cout[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin);
        cout[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
                | (prop[2] & prop[1] & prop[0] & cin);
        cout[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                | (prop[3] & prop[2] & prop[1] & gen[0])
                | (prop[3] & prop[2] & prop[1] & prop[0] & cin);
    end

    // Purpose: form each sum bit from its propagate term and incoming carry.
    always_comb begin
        sum = prop ^ {cout[3:1], cin};
    end
endmodule

// File: rtl/adsub_carry_chain.sv
// Module: word-wide adder built from 4-bit lookahead lanes.
// Lanes are chained by ripple. The module exposes the carry out of the
// top bit and the carry into it.
// Assumes: WIDTH is a multiple of LANE_W.
module adsub_carry_chain
    import adsub_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top,
    output logic             carry_sign
);
    localparam int LANES = WIDTH / LANE_W;

    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH:0]   carry;

    // Purpose: per-bit generate and propagate terms.
    always_comb begin
        gen_w  = a & b;
        prop_w = a ^ b;
    end

    assign carry[0] = cin;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        adsub_cla4 u_lane (
            .gen  (gen_w [k*LANE_W +: LANE_W]),
            .prop (prop_w[k*LANE_W +: LANE_W]),
            .cin  (carry [k*LANE_W]),
            .sum  (sum   [k*LANE_W +: LANE_W]),
            .cout (carry [k*LANE_W+1 +: LANE_W])
        );
    end

    assign carry_top  = carry[WIDTH];
    assign carry_sign = carry[WIDTH-1];
endmodule

// File: rtl/adsub_dual_flag.sv
// Module: top-level adder-subtracter with unsigned and signed overflow flags.
// Combinational only; there is no clock or reset in this block.
// Assumes: WIDTH is a multiple of 4 (checked at elaboration).
module adsub_dual_flag
    import adsub_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             mode,
    output logic [WIDTH-1:0] result,
    output logic             unsigned_flag,
    output logic             signed_flag
);
    // R8: the lane structure needs a whole number of 4-bit lanes
    if ((WIDTH % LANE_W) != 0 || WIDTH < LANE_W) begin : g_bad_width
        $error("adsub_dual_flag: WIDTH must be a positive multiple of 4");
    end

    logic [WIDTH-1:0] y_cond;
    logic             seed;
    logic             c_top;
    logic             c_sign;

    adsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .y_in       (y),
        .mode       (mode),
        .y_cond     (y_cond),
        .carry_seed (seed)
    );

    adsub_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .a          (x),
        .b          (y_cond),
        .cin        (seed),
        .sum        (result),
        .carry_top  (c_top),
        .carry_sign (c_sign)
    );

    // Purpose: derive both flags from the top two carries.
    always_comb begin
        unsigned_flag = c_top ^ mode;
        signed_flag   = c_top ^ c_sign;
    end
endmodule

// File: rtl/adsub_dual_flag_chk.sv
// Module: property checker for adsub_dual_flag, attached by bind.
// Compares the outputs with word-wide reference arithmetic and with
// sign-bit rules, after the combinational inputs have settled.
module adsub_dual_flag_chk #(
    parameter int WIDTH = 12
) (
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             mode,
    input logic [WIDTH-1:0] result,
    input logic             unsigned_flag,
    input logic             signed_flag
);
    logic [WIDTH:0] wide_add;
    logic [WIDTH:0] wide_sub;
    logic           same_sign;
    logic           diff_sign;
    logic           res_flip;

    // Purpose: evaluate every property on the settled values.
    always_comb begin
        wide_add  = {1'b0, x} + {1'b0, y};
        wide_sub  = {1'b0, x} - {1'b0, y};
        same_sign = (x[WIDTH-1] == y[WIDTH-1]);
        diff_sign = (x[WIDTH-1] != y[WIDTH-1]);
        res_flip  = (result[WIDTH-1] != x[WIDTH-1]);
        if (mode == 1'b0) begin
            // R1
            sum_chk: assert (result == wide_add[WIDTH-1:0]);
            // R3
            carry_chk: assert (unsigned_flag == wide_add[WIDTH]);
            // R5
            ovf_add_chk: assert (signed_flag == (same_sign && res_flip));
        end else begin
            // R2
            diff_chk: assert (result == wide_sub[WIDTH-1:0]);
            // R4
            borrow_chk: assert (unsigned_flag == (x < y));
            // R6
            ovf_sub_chk: assert (signed_flag == (diff_sign && res_flip));
        end
    end
endmodule

bind adsub_dual_flag adsub_dual_flag_chk #(.WIDTH(WIDTH)) u_chk (
    .x             (x),
    .y             (y),
    .mode          (mode),
    .result        (result),
    .unsigned_flag (unsigned_flag),
    .signed_flag   (signed_flag)
);

// File: tb/test_adsub_dual_flag.sv
`timescale 1ns/1ps
// Bench: table-driven checks, then directed and pseudo-random operands.
module test_adsub_dual_flag;
    localparam int W = 12;
    localparam int NVEC = 14;

    // Vector entry layout: {mode, x, y}
    localparam logic [2*W:0] VEC [0:NVEC-1] = '{
        {1'b0, 12'h000, 12'h000},
        {1'b0, 12'h7FF, 12'h001},  // signed ovf only (R5)
        {1'b0, 12'hFFF, 12'h001},  // carry only (R3)
        {1'b0, 12'h800, 12'h800},  // both flags (R7)
        {1'b0, 12'h800, 12'hFFF},  // both flags
        {1'b0, 12'h123, 12'h456},
        {1'b0, 12'hFFF, 12'hFFF},
        {1'b1, 12'h000, 12'h000},
        {1'b1, 12'h000, 12'h800},  // both flags (R7)
        {1'b1, 12'h000, 12'h001},  // borrow only (R4)
        {1'b1, 12'h800, 12'h001},  // signed ovf only (R6)
        {1'b1, 12'h7FF, 12'hFFF},  // both flags
        {1'b1, 12'h456, 12'h123},
        {1'b1, 12'hFFF, 12'hFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic         mode = 1'b0;
    logic [W-1:0] result;
    logic         unsigned_flag;
    logic         signed_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adsub_dual_flag #(.WIDTH(W)) i_adsub_dual_flag (
        .x             (x),
        .y             (y),
        .mode          (mode),
        .result        (result),
        .unsigned_flag (unsigned_flag),
        .signed_flag   (signed_flag)
    );

    function automatic int to_signed(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (mode=%0d x=%h y=%h)",
                     req, act, exp, mode, x, y);
        end
    endtask

    // Drive one operation, wait for it to settle, then compare against integer math.
    task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
        int ua, ub, sa, sb, full, sfull, exp_res, exp_u, exp_s;
        @(negedge clk);
        mode = m; x = a; y = b;
        @(posedge clk);
        #1;
        ua = int'(a); ub = int'(b);
        sa = to_signed(a); sb = to_signed(b);
        if (!m) begin
            full  = ua + ub;
            sfull = sa + sb;
            exp_u = (full >= (1 << W)) ? 1 : 0;
        end else begin
            full  = ua - ub;
            sfull = sa - sb;
            exp_u = (ua < ub) ? 1 : 0;
        end
        exp_res = full & ((1 << W) - 1);
        exp_s   = (sfull > (1 << (W-1)) - 1 || sfull < -(1 << (W-1))) ? 1 : 0;
        if (!m) begin
            check("R1 sum", int'(result), exp_res);
            check("R3 carry", int'(unsigned_flag), exp_u);
            check("R5 signed ovf add", int'(signed_flag), exp_s);
        end else begin
            check("R2 difference", int'(result), exp_res);
            check("R4 borrow", int'(unsigned_flag), exp_u);
            check("R6 signed ovf sub", int'(signed_flag), exp_s);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: zero operands in add mode give zero with both flags clear.
        check("R1 idle result", int'(result), 0);
        check("R3 idle carry", int'(unsigned_flag), 0);
        check("R5 idle signed", int'(signed_flag), 0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
        end

        // R7: both flags together, checked directly.
        apply(1'b0, 12'h800, 12'h800);
        check("R7 both flags add", int'(unsigned_flag & signed_flag), 1);
        check("R7 result zero", int'(result), 0);
        apply(1'b1, 12'h000, 12'h800);
        check("R7 both flags sub", int'(unsigned_flag & signed_flag), 1);

        // R8: the default width of 12 gives the expected wrap.
        apply(1'b0, 12'hFFF, 12'h002);
        check("R8 wrap at 12 bits", int'(result), 1);

        // Corner operands: every pair from {0, max, min, -1}, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [W-1:0] ca, cb;
                    ca = (i == 0) ? 12'h000 : (i == 1) ? 12'h7FF : (i == 2) ? 12'h800 : 12'hFFF;
                    cb = (j == 0) ? 12'h000 : (j == 1) ? 12'h7FF : (j == 2) ? 12'h800 : 12'hFFF;
                    apply(m[0], ca, cb);
                end
            end
        end

        // Pseudo-random operands from an LFSR.
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra, rb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr[W-1:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb = lfsr[W-1:0] ^ lfsr[15:4];
            apply(lfsr[7], ra, rb);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule